// File: doc/BRIEF.md
# Block-Replicated VGA Display Controller

This block generates raster timing for a 640 by 480 display refreshed at 60 Hz. The screen is treated as a coarse grid of square cells, each 8 by 8 physical pixels wide and painted in a single colour, which gives 80 columns by 60 rows. While the beam sweeps the screen, the block presents the cell column, the cell row and a linear cell index. A tile or frame buffer uses these to look up the colour of the cell under the beam.

The buffer is read through a port with one clock of latency. The block delays its active-low horizontal and vertical sync outputs and its blanking flag by one clock, so they line up with the returned colour word. It drives black outside the visible area. Pixels advance on an internal enable that fires once every `CLK_DIV` system clocks; the default of 4 gives a 25 MHz pixel rate from a 100 MHz clock. All porch, sync and visible lengths are parameters. The defaults are 800 clocks per line (640 visible, 16 front porch, 96 sync, 48 back porch) and 525 lines per frame (480 visible, 10 front porch, 2 sync, 33 back porch).

Top module: `vga_sp_ctrl`

## Requirements
- R1: While `rst_n` is low, `hsync_n_o` and `vsync_n_o` are 1, `blank_o` is 1, `pixel_o` is 0, and the cell column, row and index outputs are 0.
- R2: After reset is released, the beam position advances by one pixel every `CLK_DIV` clocks. The cell outputs therefore hold each value for exactly `CLK_DIV` consecutive clocks.
- R3: A line lasts H_VIS+H_FP+H_SW+H_BP pixels. The undelayed horizontal sync is low (0) for pixel positions H_VIS+H_FP through H_VIS+H_FP+H_SW-1, and high elsewhere.
- R4: The line count advances when a line ends. A frame lasts V_VIS+V_FP+V_SW+V_BP lines. Vertical sync is low for lines V_VIS+V_FP through V_VIS+V_FP+V_SW-1. After the last pixel of the last line, the position returns to pixel 0 of line 0.
- R5: Blanking is 1 whenever the pixel position is at or beyond H_VIS, or the line is at or beyond V_VIS. It is 0 otherwise.
- R6: In the visible area, the cell column is the pixel position shifted right by 3 and the cell row is the line number shifted right by 3.
- R7: The cell index equals row × (H_VIS/8) + column, and it is always below (H_VIS/8)×(V_VIS/8).
- R8: While the undelayed blanking condition holds, the cell column, row and index outputs are all 0.
- R9: `hsync_n_o`, `vsync_n_o` and `blank_o` show the timing of the position the cell outputs held one clock earlier. `rd_data_i` is taken as the colour of the index presented one clock earlier.
- R10: `pixel_o` is 0 whenever `blank_o` is 1. Otherwise it equals `rd_data_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_col_o | output | COL_W | Cell column under the beam |
| cell_row_o | output | ROW_W | Cell row under the beam |
| cell_addr_o | output | ADDR_W | Linear cell index for the buffer read |
| rd_data_i | input | COLOR_W | Colour word returned one clock after the index |
| hsync_n_o | output | 1 | Horizontal sync, active low, aligned to read data |
| vsync_n_o | output | 1 | Vertical sync, active low, aligned to read data |
| blank_o | output | 1 | High outside the visible area, aligned to read data |
| pixel_o | output | COLOR_W | Colour to the display, black while blanked |

## Verification
Two events can land on the same pixel tick: the end-of-line wrap of the horizontal count and the end-of-frame wrap of the line count. To provoke this, the bench runs past the final pixel of the final line of a reduced-size raster. It then checks that the cell outputs return to index 0 on that tick, while the delayed sync and blank outputs still describe the blanked last pixel for one more clock. A second coincidence is also judged. At the first visible pixel after blanking, the colour forcing releases in the same clock that the buffer returns its first word; the bench expects the stored pattern for index 0 there, not black.

// File: rtl/vga_sp_pkg.sv
package vga_sp_pkg;

   // Timing flags carried through the one-clock alignment stage
   typedef struct packed {
      logic hs_n;
      logic vs_n;
      logic blank;
   } vga_sp_ctl_t;

   localparam vga_sp_ctl_t CTL_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, blank: 1'b1};

endpackage

// File: rtl/vga_sp_tick.sv
// Pixel-rate enable: one pulse every DIV system clocks.
module vga_sp_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_full_rate
         assign tick = 1'b1;
      end else begin : g_divided
         localparam int DW = $clog2(DIV);
         localparam logic [DW-1:0] LAST = DW'(DIV - 1);
         logic [DW-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (div_q == LAST)  div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end

         assign tick = (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/vga_sp_axis.sv
// One raster axis: position counter with visible, sync and wrap decode.
module vga_sp_axis #(
   parameter int VIS = 640,
   parameter int FP  = 16,
   parameter int SW  = 96,
   parameter int BP  = 48,
   localparam int TOT = VIS + FP + SW + BP,
   localparam int CW  = $clog2(TOT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [CW-1:0] cnt,
   output logic          last,
   output logic          active,
   output logic          sync_n
);
   localparam logic [CW-1:0] END_POS = CW'(TOT - 1);
   localparam logic [CW-1:0] VIS_END = CW'(VIS);
   localparam logic [CW-1:0] SYNC_LO = CW'(VIS + FP);
   localparam logic [CW-1:0] SYNC_HI = CW'(VIS + FP + SW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (step)  cnt <= last ? '0 : cnt + 1'b1;
   end

   assign last   = (cnt == END_POS);
   assign active = (cnt < VIS_END);
   assign sync_n = !((cnt >= SYNC_LO) && (cnt < SYNC_HI));
endmodule

// File: rtl/vga_sp_cell.sv
// Coarse cell coordinates and linear index from the raster position.
module vga_sp_cell #(
   parameter int HCW       = 10,
   parameter int VCW       = 10,
   parameter int CELL_LOG2 = 3,
   parameter int COLS      = 80,
   parameter int COL_W     = 7,
   parameter int ROW_W     = 6,
   parameter int ADDR_W    = 13
) (
   input  logic [HCW-1:0]    h_cnt,
   input  logic [VCW-1:0]    v_cnt,
   input  logic              visible,
   output logic [COL_W-1:0]  col,
   output logic [ROW_W-1:0]  row,
   output logic [ADDR_W-1:0] addr
);
   logic [HCW-1:0] h_sh;
   logic [VCW-1:0] v_sh;

   assign h_sh = h_cnt >> CELL_LOG2;
   assign v_sh = v_cnt >> CELL_LOG2;
   assign col  = visible ? COL_W'(h_sh) : '0;
   assign row  = visible ? ROW_W'(v_sh) : '0;

   generate
      if ((COLS & (COLS - 1)) == 0) begin : g_pow2_cols
         assign addr = ADDR_W'({row, col});
      end else begin : g_mul_cols
         assign addr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);
      end
   endgenerate
endmodule

// File: rtl/vga_sp_ctrl.sv
module vga_sp_ctrl
   import vga_sp_pkg::*;
#(
   parameter int CLK_DIV   = 4,
   parameter int H_VIS     = 640,
   parameter int H_FP      = 16,
   parameter int H_SW      = 96,
   parameter int H_BP      = 48,
   parameter int V_VIS     = 480,
   parameter int V_FP      = 10,
   parameter int V_SW      = 2,
   parameter int V_BP      = 33,
   parameter int CELL_LOG2 = 3,
   parameter int COLOR_W   = 8,
   localparam int COLS   = H_VIS >> CELL_LOG2,
   localparam int ROWS   = V_VIS >> CELL_LOG2,
   localparam int COL_W  = $clog2(COLS),
   localparam int ROW_W  = $clog2(ROWS),
   localparam int ADDR_W = $clog2(COLS * ROWS)
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [COL_W-1:0]   cell_col_o,
   output logic [ROW_W-1:0]   cell_row_o,
   output logic [ADDR_W-1:0]  cell_addr_o,
   input  logic [COLOR_W-1:0] rd_data_i,
   output logic               hsync_n_o,
   output logic               vsync_n_o,
   output logic               blank_o,
   output logic [COLOR_W-1:0] pixel_o
);
   localparam int H_TOT = H_VIS + H_FP + H_SW + H_BP;
   localparam int V_TOT = V_VIS + V_FP + V_SW + V_BP;
   localparam int HCW   = $clog2(H_TOT);
   localparam int VCW   = $clog2(V_TOT);
   localparam int CELL  = 1 << CELL_LOG2;

   // Elaboration-time parameter checks
   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if ((H_VIS % CELL) != 0 || (V_VIS % CELL) != 0) begin : g_bad_grid
         $error("visible size must be a multiple of the cell size");
      end
      if (COLS < 2 || ROWS < 2) begin : g_bad_cells
         $error("grid must have at least two cells on each axis");
      end
      if (H_SW < 1 || V_SW < 1) begin : g_bad_sync
         $error("sync widths must be non-zero");
      end
   endgenerate

   logic           pix_tick;
   logic [HCW-1:0] h_cnt;
   logic [VCW-1:0] v_cnt;
   logic           h_last, v_last;
   logic           h_act, v_act;
   logic           hs_raw, vs_raw;
   logic           visible;
   vga_sp_ctl_t    ctl_q;

   vga_sp_tick #(.DIV(CLK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (pix_tick)
   );

   vga_sp_axis #(.VIS(H_VIS), .FP(H_FP), .SW(H_SW), .BP(H_BP)) u_h (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_tick),
      .cnt   (h_cnt),
      .last  (h_last),
      .active(h_act),
      .sync_n(hs_raw)
   );

   vga_sp_axis #(.VIS(V_VIS), .FP(V_FP), .SW(V_SW), .BP(V_BP)) u_v (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_tick & h_last),
      .cnt   (v_cnt),
      .last  (v_last),
      .active(v_act),
      .sync_n(vs_raw)
   );

   assign visible = h_act & v_act;

   vga_sp_cell #(
      .HCW(HCW), .VCW(VCW), .CELL_LOG2(CELL_LOG2), .COLS(COLS),
      .COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
   ) u_cell (
      .h_cnt  (h_cnt),
      .v_cnt  (v_cnt),
      .visible(visible),
      .col    (cell_col_o),
      .row    (cell_row_o),
      .addr   (cell_addr_o)
   );

   // Alignment stage matching the buffer read latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= CTL_IDLE;
      else        ctl_q <= '{hs_n: hs_raw, vs_n: vs_raw, blank: !visible};
   end

   assign hsync_n_o = ctl_q.hs_n;
   assign vsync_n_o = ctl_q.vs_n;
   assign blank_o   = ctl_q.blank;
   assign pixel_o   = ctl_q.blank ? '0 : rd_data_i;

   logic unused_v_last;
   assign unused_v_last = v_last;
endmodule

// File: rtl/vga_sp_chk.sv
module vga_sp_chk #(
   parameter int H_TOT   = 800,
   parameter int V_TOT   = 525,
   parameter int HCW     = 10,
   parameter int VCW     = 10,
   parameter int ADDR_W  = 13,
   parameter int CELLS   = 4800,
   parameter int COLOR_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pix_tick,
   input logic               h_last,
   input logic [HCW-1:0]     h_cnt,
   input logic [VCW-1:0]     v_cnt,
   input logic               hs_raw,
   input logic               vs_raw,
   input logic [ADDR_W-1:0]  cell_addr_o,
   input logic               hsync_n_o,
   input logic               vsync_n_o,
   input logic               blank_o,
   input logic [COLOR_W-1:0] pixel_o
);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_tick |=> $stable(h_cnt) && $stable(v_cnt));

   p_hsync_in_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hsync_n_o |-> blank_o);

   p_vsync_in_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_n_o |-> blank_o);

   p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pix_tick && h_last && (v_cnt == VCW'(V_TOT - 1))
      |=> (h_cnt == '0) && (v_cnt == '0));

   p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cell_addr_o) < CELLS);

   p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (hsync_n_o == $past(hs_raw)) && (vsync_n_o == $past(vs_raw)));

   p_blank_black_r10: assert property (@(posedge clk) disable iff (!rst_n)
      blank_o |-> (pixel_o == '0));

   logic unused_h;
   assign unused_h = (H_TOT == 0);
endmodule

bind vga_sp_ctrl vga_sp_chk #(
   .H_TOT(H_TOT), .V_TOT(V_TOT), .HCW(HCW), .VCW(VCW),
   .ADDR_W(ADDR_W), .CELLS(COLS * ROWS), .COLOR_W(COLOR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_tick   (pix_tick),
   .h_last     (h_last),
   .h_cnt      (h_cnt),
   .v_cnt      (v_cnt),
   .hs_raw     (hs_raw),
   .vs_raw     (vs_raw),
   .cell_addr_o(cell_addr_o),
   .hsync_n_o  (hsync_n_o),
   .vsync_n_o  (vsync_n_o),
   .blank_o    (blank_o),
   .pixel_o    (pixel_o)
);

// File: tb/vga_sp_ctrl_tb.sv
module vga_sp_ctrl_tb;
   localparam int PERIOD = 10;
   localparam int D      = 2;
   localparam int HV = 32, HFP = 2, HSW = 4, HBP = 2;
   localparam int VV = 16, VFP = 1, VSW = 2, VBP = 1;
   localparam int HT = HV + HFP + HSW + HBP;   // 40
   localparam int VT = VV + VFP + VSW + VBP;   // 20
   localparam int FRAME = HT * VT * D;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] col;
   logic [0:0] row;
   logic [2:0] addr;
   logic [7:0] rd_data = '0;
   logic       hs_n, vs_n, blank;
   logic [7:0] pixel;
   int         cyc = 0;
   int         checks = 0;
   int         errors = 0;

   always #(PERIOD/2) clk = ~clk;

   vga_sp_ctrl #(
      .CLK_DIV(D), .H_VIS(HV), .H_FP(HFP), .H_SW(HSW), .H_BP(HBP),
      .V_VIS(VV), .V_FP(VFP), .V_SW(VSW), .V_BP(VBP),
      .CELL_LOG2(3), .COLOR_W(8)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cell_col_o(col), .cell_row_o(row), .cell_addr_o(addr),
      .rd_data_i(rd_data),
      .hsync_n_o(hs_n), .vsync_n_o(vs_n), .blank_o(blank), .pixel_o(pixel)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 5) & 255);
   endfunction

   // Buffer model: one clock of read latency
   always @(posedge clk) rd_data <= pat(int'(addr));

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic wait_to(int k);
      while (cyc < k) @(negedge clk);
   endtask

   // {h, v, col, row, addr, hs_n, vs_n, blank}
   localparam int NV = 15;
   localparam int TBL [NV][8] = '{
      '{ 0,  0, 0, 0, 0, 1, 1, 0},
      '{ 7,  0, 0, 0, 0, 1, 1, 0},
      '{ 8,  0, 1, 0, 1, 1, 1, 0},
      '{31,  0, 3, 0, 3, 1, 1, 0},
      '{32,  0, 0, 0, 0, 1, 1, 1},
      '{34,  0, 0, 0, 0, 0, 1, 1},
      '{37,  0, 0, 0, 0, 0, 1, 1},
      '{38,  0, 0, 0, 0, 1, 1, 1},
      '{ 9,  7, 1, 0, 1, 1, 1, 0},
      '{ 9,  8, 1, 1, 5, 1, 1, 0},
      '{31, 15, 3, 1, 7, 1, 1, 0},
      '{ 0, 16, 0, 0, 0, 1, 1, 1},
      '{ 5, 17, 0, 0, 0, 1, 0, 1},
      '{35, 18, 0, 0, 0, 0, 0, 1},
      '{ 0, 19, 0, 0, 0, 1, 1, 1}
   };

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "hsync_n", hs_n, 1);
      chk("R1", "vsync_n", vs_n, 1);
      chk("R1", "blank", blank, 1);
      chk("R1", "pixel", pixel, 0);
      chk("R1", "addr", addr, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         int k;
         k = (TBL[i][1] * HT + TBL[i][0]) * D;
         wait_to(k);
         // R6/R7/R8: cell outputs for this raster position
         chk("R6", "col", col, TBL[i][2]);
         chk("R6", "row", row, TBL[i][3]);
         chk(TBL[i][7] != 0 ? "R8" : "R7", "addr", addr, TBL[i][4]);
         wait_to(k + 1);
         // R2: position held for the second clock of the pixel
         chk("R2", "addr hold", addr, TBL[i][4]);
         // R3/R4/R5/R9: delayed flags of this position
         chk("R3", "hsync_n", hs_n, TBL[i][5]);
         chk("R4", "vsync_n", vs_n, TBL[i][6]);
         chk("R5", "blank", blank, TBL[i][7]);
         // R10: black while blanked, else buffer word of this index
         chk("R10", "pixel", pixel, TBL[i][7] != 0 ? 0 : int'(pat(TBL[i][4])));
      end

      // R4: line and frame wrap on the same tick
      wait_to(FRAME);
      chk("R4", "wrap addr", addr, 0);
      chk("R4", "wrap col", col, 0);
      chk("R9", "blank of last pixel", blank, 1);
      chk("R9", "pixel of last pixel", pixel, 0);
      wait_to(FRAME + 1);
      chk("R9", "blank after wrap", blank, 0);
      chk("R10", "first word after blank", pixel, int'(pat(0)));

      // R1: reset in the middle of the visible area
      wait_to(FRAME + (5 * HT + 20) * D);
      chk("R7", "mid addr", addr, 2);
      rst_n = 1'b0;
      #1;
      chk("R1", "mid-reset addr", addr, 0);
      chk("R1", "mid-reset blank", blank, 1);
      chk("R1", "mid-reset pixel", pixel, 0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_to(3 * D);
      chk("R2", "restart col", col, 0);
      wait_to(8 * D);
      chk("R2", "restart col 8", col, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule